// File: doc/BRIEF.md
# UART Modem Handshake Register Block

This block holds the modem control and modem status registers of a 16550-style serial port. A host reaches both registers through a plain register port made of a select, a read strobe, a write strobe, an address and a data bus. The control register drives the active-low request-to-send output and carries the loop-mode bit. The status register reports the ring-indicator line. The ring-indicator input is asynchronous, so it passes through a synchronizer before it is used.

A rising ring-indicator line sets a sticky change flag. Reading the status register clears that flag. While the modem-status interrupt enable input is high, a set flag raises the interrupt request. Loop mode always holds request-to-send inactive, whatever the control bit says. The other modem lines have reserved bit positions only and read as zero.

Top module: `uart_mdm_ctl`

## Requirements
- R1: After reset, rts_n is 1, loop_mode is 0, irq is 0, the control register reads 8'h00 and the status register reads bit 2 as 0.
- R2: A write with cs and wr_stb high at address 4 stores wdata[4:0] in the control register on that clock edge. Reading address 4 returns those five bits, with bits 7:5 read as 0.
- R3: rts_n is 0 exactly when control bit 1 (request) is 1 and control bit 4 (loop) is 0. Otherwise it is 1.
- R4: loop_mode always equals control register bit 4.
- R5: Status bit 6 at address 6 shows the ring-indicator input after two clock edges of synchronization.
- R6: Status bit 2 sets one clock edge after the synchronized ring-indicator goes from 0 to 1. A fall from 1 to 0 never sets it.
- R7: A read of address 6 (cs and rd_stb high) clears status bit 2 on the clock edge that ends the read. If a new rise is detected in that same cycle, the bit stays set.
- R8: irq equals status bit 2 ANDed with msi_en. msi_en is a level input and takes effect without a clock edge.
- R9: Strobes without cs, and writes to any address other than 4, leave the control register unchanged. rdata reads 8'h00 at every address other than 4 and 6, and whenever no read is in progress.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cs | input | 1 | Block select |
| rd_stb | input | 1 | Read strobe, active high |
| wr_stb | input | 1 | Write strobe, active high |
| addr | input | 3 | Register address (4 = control, 6 = status) |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Read data, combinational during a read |
| ri_in | input | 1 | Asynchronous ring-indicator line, active high |
| msi_en | input | 1 | Modem-status interrupt enable |
| rts_n | output | 1 | Request to send, active low |
| loop_mode | output | 1 | Loop-mode control bit |
| irq | output | 1 | Modem-status interrupt request |

## Verification
The assertions check several things on every cycle:
- the control register loads on a decoded write and holds otherwise;
- the change flag sets after a detected rise, holds until a read, and clears on a read that has no coinciding rise;
- a detected rise lasts a single cycle;
- loop mode keeps request-to-send inactive;
- a disabled enable keeps irq low.

Some behaviours only the bench scenarios can show:
- the exact two-edge latency from the pin to status bit 6;
- that a falling ring line leaves the flag clear;
- the same-cycle race between a read and a rise;
- the complete readback and request-to-send decoding over all 32 control values.

// File: rtl/uart_mdm_pkg.sv
package uart_mdm_pkg;
  localparam int CTRL_OFFSET = 4;
  localparam int STAT_OFFSET = 6;
  localparam int CTRL_BITS   = 5;
  localparam int CTRL_REQ    = 1;
  localparam int CTRL_LOOP   = 4;
  localparam int STAT_RING   = 6;
  localparam int STAT_RFLAG  = 2;
endpackage

// File: rtl/uart_mdm_ri_sync.sv
module uart_mdm_ri_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic ri_async,
  output logic ri_sync,
  output logic ri_rise
);
  logic [STAGES-1:0] chain_q;
  logic              prev_q;

  generate
    for (genvar g = 0; g < STAGES; g++) begin : g_stage
      if (g == 0) begin : g_first
        always_ff @(posedge clk or negedge rst_n)
          if (!rst_n) chain_q[0] <= 1'b0;
          else        chain_q[0] <= ri_async;
      end else begin : g_next
        always_ff @(posedge clk or negedge rst_n)
          if (!rst_n) chain_q[g] <= 1'b0;
          else        chain_q[g] <= chain_q[g-1];
      end
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) prev_q <= 1'b0;
    else        prev_q <= chain_q[STAGES-1];

  assign ri_sync = chain_q[STAGES-1];
  assign ri_rise = chain_q[STAGES-1] & ~prev_q;

  AST_RISE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    ri_rise |=> !ri_rise); // R6
endmodule

// File: rtl/uart_mdm_ctrl_reg.sv
module uart_mdm_ctrl_reg #(
  parameter int DATA_W = 8,
  parameter int BITS   = 5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [DATA_W-1:0] wdata,
  output logic [BITS-1:0]   ctrl_q
);
  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n)     ctrl_q <= '0;
    else if (wr_en) ctrl_q <= wdata[BITS-1:0];

  AST_CTRL_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |=> ctrl_q == $past(wdata[BITS-1:0])); // R2
  AST_CTRL_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_en |=> $stable(ctrl_q)); // R9
endmodule

// File: rtl/uart_mdm_stat_reg.sv
module uart_mdm_stat_reg (
  input  logic clk,
  input  logic rst_n,
  input  logic ri_rise,
  input  logic rd_clr,
  output logic flag_q
);
  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n)       flag_q <= 1'b0;
    else if (ri_rise) flag_q <= 1'b1;
    else if (rd_clr)  flag_q <= 1'b0;

  AST_FLAG_SET: assert property (@(posedge clk) disable iff (!rst_n)
    ri_rise |=> flag_q); // R6
  AST_FLAG_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    flag_q && !rd_clr |=> flag_q); // R7
  AST_FLAG_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    rd_clr && !ri_rise |=> !flag_q); // R7
endmodule

// File: rtl/uart_mdm_ctl.sv
module uart_mdm_ctl
  import uart_mdm_pkg::*;
#(
  parameter int ADDR_W      = 3,
  parameter int DATA_W      = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cs,
  input  logic              rd_stb,
  input  logic              wr_stb,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] rdata,
  input  logic              ri_in,
  input  logic              msi_en,
  output logic              rts_n,
  output logic              loop_mode,
  output logic              irq
);
  localparam logic [ADDR_W-1:0] CTRL_A = ADDR_W'(CTRL_OFFSET);
  localparam logic [ADDR_W-1:0] STAT_A = ADDR_W'(STAT_OFFSET);

  logic                 ctrl_wr, stat_rd;
  logic [CTRL_BITS-1:0] ctrl_q;
  logic                 ri_sync, ri_rise, flag_q;

  assign ctrl_wr = cs && wr_stb && (addr == CTRL_A);
  assign stat_rd = cs && rd_stb && (addr == STAT_A);

  uart_mdm_ri_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .ri_async(ri_in),
    .ri_sync(ri_sync), .ri_rise(ri_rise)
  );

  uart_mdm_ctrl_reg #(.DATA_W(DATA_W), .BITS(CTRL_BITS)) u_ctrl (
    .clk(clk), .rst_n(rst_n), .wr_en(ctrl_wr), .wdata(wdata), .ctrl_q(ctrl_q)
  );

  uart_mdm_stat_reg u_stat (
    .clk(clk), .rst_n(rst_n), .ri_rise(ri_rise), .rd_clr(stat_rd), .flag_q(flag_q)
  );

  always_comb begin
    rdata = '0;
    if (cs && rd_stb) begin
      if (addr == CTRL_A) begin
        rdata[CTRL_BITS-1:0] = ctrl_q;
      end else if (addr == STAT_A) begin
        rdata[STAT_RING]  = ri_sync;
        rdata[STAT_RFLAG] = flag_q;
      end
    end
  end

  assign loop_mode = ctrl_q[CTRL_LOOP];
  assign rts_n     = ~(ctrl_q[CTRL_REQ] & ~ctrl_q[CTRL_LOOP]);
  assign irq       = flag_q & msi_en;

  AST_RTS_LOOP_OFF: assert property (@(posedge clk) disable iff (!rst_n)
    loop_mode |-> rts_n); // R3
  AST_IRQ_MASKED: assert property (@(posedge clk) disable iff (!rst_n)
    !msi_en |-> !irq); // R8
endmodule

// File: tb/uart_mdm_ctl_test.sv
module uart_mdm_ctl_test;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       cs = 1'b0, rd_stb = 1'b0, wr_stb = 1'b0;
  logic [2:0] addr = '0;
  logic [7:0] wdata = '0;
  logic [7:0] rdata;
  logic       ri_in = 1'b0, msi_en = 1'b0;
  logic       rts_n, loop_mode, irq;
  int         n_chk = 0, n_fail = 0;
  logic [7:0] v;

  always #4 clk = ~clk;

  uart_mdm_ctl uut (
    .clk(clk), .rst_n(rst_n), .cs(cs), .rd_stb(rd_stb), .wr_stb(wr_stb),
    .addr(addr), .wdata(wdata), .rdata(rdata), .ri_in(ri_in), .msi_en(msi_en),
    .rts_n(rts_n), .loop_mode(loop_mode), .irq(irq)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wr_reg(input logic [2:0] a, input logic [7:0] d, input logic sel);
    @(negedge clk); cs = sel; wr_stb = 1'b1; addr = a; wdata = d;
    @(negedge clk); cs = 1'b0; wr_stb = 1'b0;
  endtask

  task automatic rd_reg(input logic [2:0] a, output logic [7:0] d);
    @(negedge clk); cs = 1'b1; rd_stb = 1'b1; addr = a; #1 d = rdata;
    @(negedge clk); cs = 1'b0; rd_stb = 1'b0;
  endtask

  task automatic finish_run;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  endtask

  initial begin
    #(8 * 200000);
    n_chk++; n_fail++;
    $display("FAIL watchdog actual=0 expected=1");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    check(rts_n == 1'b1, "R1 rts_n", rts_n, 1);
    check(loop_mode == 1'b0, "R1 loop_mode", loop_mode, 0);
    check(irq == 1'b0, "R1 irq", irq, 0);
    rd_reg(3'd4, v); check(v == 8'h00, "R1 ctrl", v, 0);
    rd_reg(3'd6, v); check(v[2] == 1'b0, "R1 flag", v, 0);

    // R2 R3 R4 sweep of all control values
    for (int k = 0; k < 32; k++) begin
      wr_reg(3'd4, {3'b101, 5'(k)}, 1'b1);
      rd_reg(3'd4, v);
      check(v == 8'(k), "R2 readback", v, k);
      check(rts_n == !(k[1] && !k[4]), "R3 rts_n", rts_n, !(k[1] && !k[4]));
      check(loop_mode == k[4], "R4 loop_mode", loop_mode, k[4]);
    end

    // R9 ignored accesses
    wr_reg(3'd4, 8'h02, 1'b1);
    wr_reg(3'd4, 8'h1D, 1'b0);
    rd_reg(3'd4, v); check(v == 8'h02, "R9 unselected write", v, 2);
    for (int a = 0; a < 8; a++) begin
      if (a != 4) begin
        wr_reg(3'(a), 8'h1D, 1'b1);
        rd_reg(3'd4, v); check(v == 8'h02, "R9 other address write", v, 2);
      end
      if (a != 4 && a != 6) begin
        rd_reg(3'(a), v); check(v == 8'h00, "R9 unmapped read", v, 0);
      end
    end
    @(negedge clk); addr = 3'd4; #1 check(rdata == 8'h00, "R9 idle rdata", rdata, 0);

    // R5 R6 R8 rise timing observed on irq and status
    msi_en = 1'b1;
    @(negedge clk); ri_in = 1'b1;
    @(negedge clk); check(irq == 1'b0, "R6 irq after 1 edge", irq, 0);
    @(negedge clk); check(irq == 1'b0, "R6 irq after 2 edges", irq, 0);
    @(negedge clk); check(irq == 1'b1, "R8 irq after 3 edges", irq, 1);
    rd_reg(3'd6, v); check(v == 8'h44, "R5 status ring and flag", v, 8'h44);
    check(irq == 1'b0, "R7 irq released by read", irq, 0);
    rd_reg(3'd6, v); check(v == 8'h40, "R7 flag cleared", v, 8'h40);

    // R6 fall does not set the flag
    @(negedge clk); ri_in = 1'b0;
    repeat (4) @(negedge clk);
    check(irq == 1'b0, "R6 fall irq", irq, 0);
    rd_reg(3'd6, v); check(v == 8'h00, "R6 fall status", v, 0);

    // R5 two-edge latency on status bit 6, R7 read racing a rise
    @(negedge clk); ri_in = 1'b1;
    @(negedge clk); cs = 1'b1; rd_stb = 1'b1; addr = 3'd6;
    #1 check(rdata == 8'h00, "R5 after 1 edge", rdata, 0);
    @(negedge clk);
    #1 check(rdata == 8'h40, "R5 after 2 edges", rdata, 8'h40);
    @(negedge clk); cs = 1'b0; rd_stb = 1'b0;
    #1 check(irq == 1'b1, "R7 rise wins over read", irq, 1);
    rd_reg(3'd6, v); check(v == 8'h44, "R7 flag kept", v, 8'h44);

    // R8 masking by msi_en
    msi_en = 1'b0;
    @(negedge clk); ri_in = 1'b0;
    repeat (3) @(negedge clk);
    ri_in = 1'b1;
    repeat (4) @(negedge clk);
    check(irq == 1'b0, "R8 masked", irq, 0);
    msi_en = 1'b1; #1
    check(irq == 1'b1, "R8 enabled", irq, 1);
    rd_reg(3'd6, v); check(v == 8'h44, "R6 flag under mask", v, 8'h44);

    finish_run();
  end
endmodule